// File: doc/BRIEF.md
# Multi-Mode Serial Port

This block is a full-duplex serial port with four framing modes, controlled through one control/status byte and one data byte. Writing the data byte starts a transmission. Reading the data byte returns the last accepted received byte, which is held in its own register so that the next frame can be shifted in meanwhile. Software services the port through a single interrupt line. That line is the OR of a transmit-done flag and a receive-done flag. Hardware only sets these flags; software clears them by rewriting the control byte.

Mode 0 is a half-duplex synchronous shifter. Data leaves or enters on the data pin, and the port drives a shift clock on the transmit pin. It runs at one bit per 12 clocks. Modes 1 to 3 are asynchronous, at 16 oversampling ticks per bit:
- Mode 1 sends 10-bit frames.
- Modes 2 and 3 send 11-bit frames with a programmable ninth bit.
- Mode 2 takes its tick from the clock.
- Modes 1 and 3 take their tick from an external timer overflow pulse.

A double-rate input halves the bit period in the asynchronous modes. The receiver votes on three oversamples per bit and rejects false starts. An address-filter bit lets it drop frames whose ninth bit is 0, which supports multi-drop networks.

Top module: `sio_port`

## Requirements
- R1: After reset, the control byte reads 0x00, the data byte reads 0x00, `txd` is 1, `irq` is 0 and `rxdOe` is 0.
- R2: Control byte layout:
  - bits [1:0]: mode. 0 = sync shift, 1 = 10-bit, 2 = 11-bit clock-timed, 3 = 11-bit timer-timed.
  - bit 2: receive enable.
  - bit 3: address filter.
  - bit 4: transmit ninth bit.
  - bit 5: received ninth/stop bit.
  - bit 6: transmit-done flag.
  - bit 7: receive-done flag.
- R3: Asynchronous transmit frame on `txd`:
  - Mode 1 sends start 0, then eight data bits LSB first, then stop 1.
  - Modes 2 and 3 send start 0, then eight data bits LSB first, then control bit 4, then stop 1.
  - The line idles at 1.
- R4: Bit period:
  - Mode 2: 64 clocks, or 32 clocks with `dblRate`=1.
  - Modes 1 and 3: 32 `timerOvf` pulses, or 16 pulses with `dblRate`=1.
- R5: Transmit timing:
  - Transmission starts at the next rollover of a free-running divide-by-16 tick counter. This is no more than 17 ticks after the write.
  - The transmit-done flag rises exactly 10 bit periods (mode 1) or 11 bit periods (modes 2 and 3) after the start edge.
- R6: Asynchronous receive sampling:
  - A 1-to-0 change on `rxdIn`, seen while receive enable is 1, begins a frame.
  - Each bit is taken as the 2-of-3 vote of the samples at ticks 8, 9 and 10 of that bit.
  - The received byte appears on `bufRdata`, and the stop bit (mode 1) or ninth bit (modes 2/3) appears in control bit 5.
  - A disturbance of one clock inside a bit does not change the result.
- R7: A start bit that votes 1, such as a low pulse shorter than half a bit, aborts reception without setting the receive-done flag. The receiver then waits for the next falling edge.
- R8: Receive-accept rule:
  - A finished frame is loaded only if the receive-done flag is 0 and either the filter bit is 0 or the received ninth/stop bit is 1.
  - Otherwise `bufRdata`, bit 5 and the receive-done flag are unchanged.
- R9: Mode 0 transmit:
  - Writing the data byte shifts eight bits LSB first on `rxdOut`, with `rxdOe`=1.
  - `txd` is the shift clock: each bit is 6 clocks low, then 6 clocks high.
  - The transmit-done flag rises 18 clocks after the last rising shift-clock edge.
- R10: Mode 0 receive:
  - Starts when receive enable is 1 and the receive-done flag is 0.
  - Samples `rxdIn` as the shift clock rises, LSB first, with `rxdOe`=0.
  - Loads `bufRdata` and sets the receive-done flag after eight bits.
- R11: `irq` is 1 exactly when either flag is 1. Hardware never clears a flag; a control write clears it.
- R12: With receive enable 0, an asynchronous frame on `rxdIn` leaves `bufRdata` and the receive-done flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| dblRate | input | 1 | Halves the asynchronous bit period |
| timerOvf | input | 1 | External timer overflow pulse (modes 1, 3) |
| bufWe | input | 1 | Data byte write strobe (starts transmit) |
| bufWdata | input | 8 | Byte to transmit |
| bufRdata | output | 8 | Last accepted received byte |
| ctrlWe | input | 1 | Control byte write strobe |
| ctrlWdata | input | 8 | Control byte write value |
| ctrlRdata | output | 8 | Control/status byte |
| rxdIn | input | 1 | Receive data pin input |
| rxdOut | output | 1 | Data pin output value in mode 0 transmit |
| rxdOe | output | 1 | Data pin output enable |
| txd | output | 1 | Async transmit line, or mode 0 shift clock |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle:
- the flags stay set until software writes the control byte;
- each transmit start lines up with a rollover of the divide-by-16 counter;
- a reception begins only after the line was sampled low;
- a frame accepted with the filter on always carries a ninth bit of 1.

Only the bench scenarios can show:
- the frame contents and bit periods;
- the exact cycle of the done flags;
- that majority voting rejects short glitches;
- that discarded frames leave the data register unchanged.

The bench compares `txd` on every clock of each frame against its own expected bit sequence.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    MD_SHIFT       = 2'd0,
    MD_FRAME10     = 2'd1,
    MD_FRAME11_FIX = 2'd2,
    MD_FRAME11_TMR = 2'd3
  } sioMode_t;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxSample;
    logic rxShift;
    logic rxCommit;
  } sioStrobe_t;
endpackage

// File: rtl/sio_datapath.sv
module sio_datapath
  import sio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  sioStrobe_t        strb,
  input  sioMode_t          mode,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              txNinth,
  input  logic              rxdIn,
  output logic              txBit,
  output logic              majBit,
  output logic [DATA_W-1:0] rxByte
);
  localparam int TXSR_W = DATA_W + 3;

  logic [DATA_W-1:0] txHold;
  logic [TXSR_W-1:0] txSr;
  logic [2:0]        win;
  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] rxBuf;
  logic              frameNinth;

  assign frameNinth = (mode == MD_FRAME10) ? 1'b1 : txNinth;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txSr   <= '1;
    end else begin
      if (wrStb) txHold <= wrByte;
      if (strb.txLoad) begin
        if (mode == MD_SHIFT) txSr <= {3'b111, txHold};
        else                  txSr <= {1'b1, frameNinth, txHold, 1'b0};
      end else if (strb.txShift) begin
        txSr <= {1'b1, txSr[TXSR_W-1:1]};
      end
    end
  end

  assign txBit  = txSr[0];
  assign majBit = (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      win   <= 3'b111;
      rxSr  <= '0;
      rxBuf <= '0;
    end else begin
      if (strb.rxSample) win <= {win[1:0], rxdIn};
      if (strb.rxShift)
        rxSr <= {(mode == MD_SHIFT) ? rxdIn : majBit, rxSr[DATA_W-1:1]};
      if (strb.rxCommit) rxBuf <= rxSr;
    end
  end

  assign rxByte = rxBuf;

  // R3
  tx_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.txLoad, strb.txShift}));

  // R6
  rx_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxShift, strb.rxCommit}));
endmodule

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int SLOT_CLKS = 12,
  parameter int FIX_DIV   = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dblRate,
  input  logic        timerOvf,
  input  logic        bufWe,
  input  logic        ctrlWe,
  input  logic [7:0]  ctrlWdata,
  input  logic        rxdIn,
  input  logic        txBit,
  input  logic        majBit,
  output sioStrobe_t  strb,
  output sioMode_t    mode,
  output logic        txNinth,
  output logic [7:0]  ctrlRdata,
  output logic        txd,
  output logic        rxdOut,
  output logic        rxdOe,
  output logic        irq
);
  localparam int CNT_W     = $clog2(OVS);
  localparam int SLOT_W    = $clog2(SLOT_CLKS);
  localparam int PRE_W     = $clog2(FIX_DIV);
  localparam int IDX_W     = $clog2(DATA_W + 4);
  localparam int HALF_SLOT = SLOT_CLKS / 2;
  localparam int SMP_FIRST = OVS / 2;
  localparam int SMP_DONE  = SMP_FIRST + 3;

  logic rxEn, filt, rxNinth, tiF, riF;

  // rate ticks
  logic [PRE_W-1:0] preCnt;
  logic ovfHalf, fixTick, tmrTick, tick16, asyncMode;

  // async transmit
  logic [CNT_W-1:0] txCnt;
  logic txRoll, txPend, txActive;
  logic [IDX_W-1:0] txIdx, lastIdx;

  // async receive
  logic rxPrev, rxActive, rxDecide, accept;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] rxIdx;

  // mode 0
  logic [SLOT_W-1:0] slotPh;
  logic slotEnd, m0Active, m0Rx, m0Bit;
  logic [IDX_W-1:0] m0Idx;
  logic setTi;

  assign asyncMode = (mode != MD_SHIFT);
  assign fixTick = dblRate ? (preCnt == PRE_W'(FIX_DIV/2 - 1) || preCnt == PRE_W'(FIX_DIV - 1))
                           : (preCnt == PRE_W'(FIX_DIV - 1));
  assign tmrTick = timerOvf && (dblRate || ovfHalf);
  assign tick16  = (mode == MD_FRAME11_FIX) ? fixTick : tmrTick;
  assign txRoll  = asyncMode && tick16 && (txCnt == CNT_W'(OVS - 1));
  assign lastIdx = (mode == MD_FRAME10) ? IDX_W'(DATA_W + 1) : IDX_W'(DATA_W + 2);
  assign slotEnd = (slotPh == SLOT_W'(SLOT_CLKS - 1));
  assign m0Bit   = m0Active && (m0Idx < IDX_W'(DATA_W));
  assign rxDecide = asyncMode && tick16 && rxActive && (rxCnt == CNT_W'(SMP_DONE));
  assign accept  = !riF && (!filt || majBit);

  always_comb begin
    strb = '0;
    strb.txLoad   = (asyncMode && txRoll && txPend && !txActive) ||
                    (!asyncMode && slotEnd && !m0Active && txPend);
    strb.txShift  = (asyncMode && txRoll && txActive && txIdx != lastIdx) ||
                    (!asyncMode && slotEnd && m0Bit && !m0Rx);
    strb.rxSample = asyncMode && tick16 && rxActive &&
                    rxCnt >= CNT_W'(SMP_FIRST) && rxCnt <= CNT_W'(SMP_FIRST + 2);
    strb.rxShift  = (rxDecide && rxIdx >= IDX_W'(1) && rxIdx <= IDX_W'(DATA_W)) ||
                    (!asyncMode && m0Bit && m0Rx && slotPh == SLOT_W'(HALF_SLOT - 1));
    strb.rxCommit = (rxDecide && rxIdx == IDX_W'(DATA_W + 1) && accept) ||
                    (!asyncMode && slotEnd && m0Active && m0Rx && m0Idx == IDX_W'(DATA_W));
    setTi = (asyncMode && txRoll && txActive && txIdx == lastIdx) ||
            (!asyncMode && slotEnd && m0Active && !m0Rx && m0Idx == IDX_W'(DATA_W));
  end

  // control/status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= MD_SHIFT; rxEn <= 1'b0; filt <= 1'b0; txNinth <= 1'b0;
      rxNinth <= 1'b0; tiF <= 1'b0; riF <= 1'b0;
    end else begin
      if (ctrlWe) begin
        mode    <= sioMode_t'(ctrlWdata[1:0]);
        rxEn    <= ctrlWdata[2];
        filt    <= ctrlWdata[3];
        txNinth <= ctrlWdata[4];
        rxNinth <= ctrlWdata[5];
        tiF     <= ctrlWdata[6];
        riF     <= ctrlWdata[7];
      end
      if (setTi) tiF <= 1'b1;
      if (strb.rxCommit) riF <= 1'b1;
      if (strb.rxCommit && asyncMode) rxNinth <= majBit;
    end
  end

  // tick generation and free-running transmit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0; ovfHalf <= 1'b0; txCnt <= '0; slotPh <= '0;
    end else begin
      preCnt <= (preCnt == PRE_W'(FIX_DIV - 1)) ? '0 : preCnt + PRE_W'(1);
      if (timerOvf) ovfHalf <= !ovfHalf;
      if (asyncMode && tick16) txCnt <= txCnt + CNT_W'(1);
      slotPh <= slotEnd ? '0 : slotPh + SLOT_W'(1);
    end
  end

  // transmit and mode 0 sequencing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPend <= 1'b0; txActive <= 1'b0; txIdx <= '0;
      m0Active <= 1'b0; m0Rx <= 1'b0; m0Idx <= '0;
    end else begin
      if (strb.txLoad) txPend <= 1'b0;
      if (bufWe) txPend <= 1'b1;
      if (txRoll) begin
        if (strb.txLoad) begin
          txActive <= 1'b1; txIdx <= '0;
        end else if (txActive) begin
          if (txIdx == lastIdx) txActive <= 1'b0;
          else txIdx <= txIdx + IDX_W'(1);
        end
      end
      if (!asyncMode && slotEnd) begin
        if (!m0Active) begin
          if (txPend) begin
            m0Active <= 1'b1; m0Rx <= 1'b0; m0Idx <= '0;
          end else if (rxEn && !riF) begin
            m0Active <= 1'b1; m0Rx <= 1'b1; m0Idx <= '0;
          end
        end else if (m0Idx == IDX_W'(DATA_W)) begin
          m0Active <= 1'b0;
        end else begin
          m0Idx <= m0Idx + IDX_W'(1);
        end
      end
    end
  end

  // asynchronous receiver
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev <= 1'b1; rxActive <= 1'b0; rxCnt <= '0; rxIdx <= '0;
    end else if (asyncMode && tick16) begin
      rxPrev <= rxdIn;
      if (!rxActive) begin
        if (rxEn && rxPrev && !rxdIn) begin
          rxActive <= 1'b1; rxCnt <= CNT_W'(1); rxIdx <= '0;
        end
      end else begin
        rxCnt <= rxCnt + CNT_W'(1);
        if (rxCnt == CNT_W'(OVS - 1)) rxIdx <= rxIdx + IDX_W'(1);
        if (rxCnt == CNT_W'(SMP_DONE)) begin
          if (rxIdx == '0 && majBit) rxActive <= 1'b0;
          else if (rxIdx == IDX_W'(DATA_W + 1)) rxActive <= 1'b0;
        end
      end
    end
  end

  assign txd = asyncMode ? (txActive ? txBit : 1'b1)
                         : !(m0Bit && slotPh < SLOT_W'(HALF_SLOT));
  assign rxdOut    = txBit;
  assign rxdOe     = !asyncMode && m0Bit && !m0Rx;
  assign irq       = tiF | riF;
  assign ctrlRdata = {riF, tiF, rxNinth, txNinth, filt, rxEn, mode};

  // R5
  tx_start_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> $past(txCnt) == CNT_W'(OVS - 1));

  // R11
  ti_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tiF && !ctrlWe) |=> tiF);

  // R11
  ri_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (riF && !ctrlWe) |=> riF);

  // R6
  rx_start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxActive) |-> !$past(rxdIn));

  // R8
  rx_filter_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(riF) && !$past(ctrlWe) && $past(filt) && $past(asyncMode)) |-> rxNinth);
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OVS       = 16,
  parameter int SLOT_CLKS = 12,
  parameter int FIX_DIV   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dblRate,
  input  logic              timerOvf,
  input  logic              bufWe,
  input  logic [DATA_W-1:0] bufWdata,
  output logic [DATA_W-1:0] bufRdata,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlWdata,
  output logic [7:0]        ctrlRdata,
  input  logic              rxdIn,
  output logic              rxdOut,
  output logic              rxdOe,
  output logic              txd,
  output logic              irq
);
  sioStrobe_t strb;
  sioMode_t   mode;
  logic       txNinth, txBit, majBit;

  sio_ctrl #(.DATA_W(DATA_W), .OVS(OVS), .SLOT_CLKS(SLOT_CLKS), .FIX_DIV(FIX_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .dblRate(dblRate), .timerOvf(timerOvf), .bufWe(bufWe),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata), .rxdIn(rxdIn), .txBit(txBit), .majBit(majBit),
    .strb(strb), .mode(mode), .txNinth(txNinth), .ctrlRdata(ctrlRdata), .txd(txd),
    .rxdOut(rxdOut), .rxdOe(rxdOe), .irq(irq)
  );

  sio_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(mode), .wrStb(bufWe), .wrByte(bufWdata),
    .txNinth(txNinth), .rxdIn(rxdIn), .txBit(txBit), .majBit(majBit), .rxByte(bufRdata)
  );
endmodule

// File: tb/sio_port_tb.sv
module sio_port_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, dblRate = 1'b0, timerOvf = 1'b0;
  logic bufWe = 1'b0, ctrlWe = 1'b0, rxdIn = 1'b1;
  logic [7:0] bufWdata = '0, ctrlWdata = '0;
  logic [7:0] bufRdata, ctrlRdata;
  logic rxdOut, rxdOe, txd, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_port u_dut (
    .clk(clk), .rstN(rstN), .dblRate(dblRate), .timerOvf(timerOvf), .bufWe(bufWe),
    .bufWdata(bufWdata), .bufRdata(bufRdata), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .rxdIn(rxdIn), .rxdOut(rxdOut), .rxdOe(rxdOe), .txd(txd), .irq(irq)
  );

  // timer overflow source: one pulse every 4 clocks
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      timerOvf = 1'b1;
      @(negedge clk);
      timerOvf = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mkCtrl(input int md, input bit rxe, input bit flt, input bit tx9);
    return {2'b00, 1'b0, tx9, flt, rxe, 2'(md)};
  endfunction

  task automatic writeCtrl(input logic [7:0] v);
    @(negedge clk); ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk); ctrlWe = 1'b0;
  endtask

  task automatic writeBuf(input logic [7:0] v);
    @(negedge clk); bufWe = 1'b1; bufWdata = v;
    @(negedge clk); bufWe = 1'b0;
  endtask

  // asynchronous transmit: expected line compared on every clock of the frame
  task automatic txAsync(input int md, input bit dbl, input logic [7:0] data, input bit n9,
                         input int tickClk, input string req);
    int nBits, bitClk, w, mism;
    logic [10:0] fb;
    dblRate = dbl;
    writeCtrl(mkCtrl(md, 1'b0, 1'b0, n9));
    bitClk = 16 * tickClk;
    nBits = (md == 1) ? 10 : 11;
    fb = (md == 1) ? {2'b11, data, 1'b0} : {1'b1, n9, data, 1'b0};
    writeBuf(data);
    w = 0;
    while (txd !== 1'b0 && w < 5000) begin @(negedge clk); w++; end
    check(w <= 17 * tickClk, "R5", "start delay after write (clocks)", w, 17 * tickClk);
    mism = 0;
    for (int k = 0; k < nBits * bitClk; k++) begin
      if (txd !== fb[k / bitClk]) mism++;
      if (irq !== 1'b0) mism++;
      @(negedge clk);
    end
    check(mism == 0, req, "frame mismatching clocks", mism, 0);
    check(irq === 1'b1 && ctrlRdata[6] === 1'b1, "R5", "transmit-done at frame end", int'(irq), 1);
  endtask

  task automatic rxAsync(input logic [10:0] bits, input int n, input int bitClk, input int glitchBit);
    for (int i = 0; i < n; i++) begin
      rxdIn = bits[i];
      for (int c = 0; c < bitClk; c++) begin
        if (i == glitchBit && c == bitClk / 2) rxdIn = ~bits[i];
        else rxdIn = bits[i];
        @(negedge clk);
      end
    end
    rxdIn = 1'b1;
    repeat (2 * bitClk) @(negedge clk);
  endtask

  initial begin
    int cnt, lowRun, oeBad, lows;
    logic prevTxd;
    logic [7:0] got;
    logic [7:0] m0Rx;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(ctrlRdata === 8'h00 && bufRdata === 8'h00, "R1", "reset registers", ctrlRdata, 0);
    check(txd === 1'b1 && irq === 1'b0 && rxdOe === 1'b0, "R1", "reset pins", {txd, irq, rxdOe}, 3'b100);

    // asynchronous transmit in each framing and rate
    txAsync(2, 1'b1, 8'h5C, 1'b1, 2, "R3 R4 mode2 double");
    txAsync(2, 1'b0, 8'hA3, 1'b0, 4, "R3 R4 mode2 normal");
    txAsync(1, 1'b0, 8'h3E, 1'b0, 8, "R3 R4 mode1 normal");
    txAsync(3, 1'b1, 8'hC1, 1'b1, 4, "R3 R4 mode3 double");
    // R11: flag stays set, control write clears it
    repeat (50) @(negedge clk);
    check(irq === 1'b1 && ctrlRdata[6] === 1'b1, "R11", "transmit-done held", int'(irq), 1);
    writeCtrl(mkCtrl(3, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check(irq === 1'b0 && ctrlRdata[7:6] === 2'b00, "R11", "flags cleared by write", int'(irq), 0);
    check(ctrlRdata === 8'h03, "R2", "control readback layout", ctrlRdata, 8'h03);

    // mode 0 transmit (R9)
    writeCtrl(mkCtrl(0, 1'b0, 1'b0, 1'b0));
    writeBuf(8'h6B);
    cnt = 0; lowRun = 0; oeBad = 0; lows = 0; got = '0; prevTxd = 1'b1;
    for (int t = 0; t < 400 && cnt < 8; t++) begin
      @(negedge clk);
      if (txd === 1'b0) lowRun++;
      if (prevTxd === 1'b0 && txd === 1'b1) begin
        got[cnt] = rxdOut;
        if (rxdOe !== 1'b1) oeBad++;
        if (lowRun != 6) lows++;
        lowRun = 0;
        cnt++;
      end
      prevTxd = txd;
    end
    check(got === 8'h6B, "R9", "mode0 shifted byte", got, 8'h6B);
    check(oeBad == 0 && lows == 0, "R9", "mode0 enable and clock low time", oeBad + lows, 0);
    repeat (17) @(negedge clk);
    check(irq === 1'b0, "R9", "transmit-done not yet at 17", int'(irq), 0);
    @(negedge clk);
    check(irq === 1'b1 && ctrlRdata[6] === 1'b1, "R9", "transmit-done at 18", int'(irq), 1);

    // mode 0 receive (R10)
    m0Rx = 8'hD2;
    writeCtrl(mkCtrl(0, 1'b1, 1'b0, 1'b0));
    cnt = 0; oeBad = 0; prevTxd = 1'b1;
    for (int t = 0; t < 400 && ctrlRdata[7] !== 1'b1; t++) begin
      @(negedge clk);
      if (rxdOe !== 1'b0) oeBad++;
      if (prevTxd === 1'b1 && txd === 1'b0 && cnt < 8) begin
        rxdIn = m0Rx[cnt];
        cnt++;
      end
      prevTxd = txd;
    end
    rxdIn = 1'b1;
    check(bufRdata === 8'hD2 && ctrlRdata[7] === 1'b1, "R10", "mode0 received byte", bufRdata, 8'hD2);
    check(oeBad == 0, "R10", "data pin not driven on receive", oeBad, 0);

    // asynchronous receive, mode 2 double rate (bit = 32 clocks)
    dblRate = 1'b1;
    writeCtrl(mkCtrl(2, 1'b1, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    rxAsync({1'b1, 1'b1, 8'hA5, 1'b0}, 11, 32, -1);
    check(bufRdata === 8'hA5 && ctrlRdata[7] === 1'b1, "R6", "mode2 byte", bufRdata, 8'hA5);
    check(ctrlRdata[5] === 1'b1, "R6", "ninth bit stored", int'(ctrlRdata[5]), 1);
    rxAsync({1'b1, 1'b1, 8'h3C, 1'b0}, 11, 32, -1);
    check(bufRdata === 8'hA5, "R8", "frame dropped while flag set", bufRdata, 8'hA5);
    writeCtrl(mkCtrl(2, 1'b1, 1'b1, 1'b0));
    @(negedge clk);
    check(irq === 1'b0, "R11", "receive flag cleared by write", int'(irq), 0);
    rxAsync({1'b1, 1'b0, 8'h11, 1'b0}, 11, 32, -1);
    check(bufRdata === 8'hA5 && ctrlRdata[7] === 1'b0, "R8", "filtered ninth=0 dropped", bufRdata, 8'hA5);
    rxAsync({1'b1, 1'b1, 8'h5A, 1'b0}, 11, 32, 4);
    check(bufRdata === 8'h5A && ctrlRdata[7] === 1'b1, "R8", "filtered ninth=1 accepted", bufRdata, 8'h5A);
    check(ctrlRdata[5] === 1'b1, "R6", "glitched frame ninth bit", int'(ctrlRdata[5]), 1);

    // R7: short low pulse is a false start
    writeCtrl(mkCtrl(2, 1'b1, 1'b0, 1'b0));
    rxdIn = 1'b0;
    repeat (12) @(negedge clk);
    rxdIn = 1'b1;
    repeat (400) @(negedge clk);
    check(ctrlRdata[7] === 1'b0 && bufRdata === 8'h5A, "R7", "false start ignored", bufRdata, 8'h5A);
    rxAsync({1'b1, 1'b0, 8'hC3, 1'b0}, 11, 32, -1);
    check(bufRdata === 8'hC3 && ctrlRdata[7:5] === 3'b100, "R7", "rearmed after false start", bufRdata, 8'hC3);

    // R12: receive disabled
    writeCtrl(mkCtrl(2, 1'b0, 1'b0, 1'b0));
    rxAsync({1'b1, 1'b1, 8'h77, 1'b0}, 11, 32, -1);
    check(bufRdata === 8'hC3 && ctrlRdata[7] === 1'b0, "R12", "disabled receiver", bufRdata, 8'hC3);

    // mode 1 receive, timer rate (bit = 128 clocks)
    dblRate = 1'b0;
    writeCtrl(mkCtrl(1, 1'b1, 1'b0, 1'b0));
    repeat (40) @(negedge clk);
    rxAsync({2'b11, 8'h96, 1'b0}, 10, 128, -1);
    check(bufRdata === 8'h96 && ctrlRdata[7:5] === 3'b101, "R6", "mode1 byte and stop bit", bufRdata, 8'h96);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule